// File: doc/BRIEF.md
# Coarse-Tick Watchdog Timer with Early-Warning Interrupt

This block is a hardware watchdog. Software loads a tick count into a 16-bit register, and the block counts that value down while it is enabled. One tick is one coarse time unit of 128 ms, which is `TICK_CYCLES` clocks. Each later load of the count register serves as a keepalive that pushes expiry back. The count register also reads back the live number of ticks left, not the value last written.

Two events can come from the countdown. A fixed number of ticks before expiry (`PRE_TICKS`, 70 by default, which is 9 s rounded down to whole ticks), the block can latch an early-warning status bit, and the non-maskable interrupt output follows that bit. When the count runs out, the block latches a timeout status bit. If reset is enabled, it also pulses a one-cycle reset request and turns its own run bit off. The interrupt routing and the reset sequencing outside the block are left to other logic.

Software reaches three registers through a plain single-cycle register port. The port has a write strobe, a byte address, and write data. Read data is a combinational function of the address. There is no data stream at this edge, so the port has no back-pressure: every write strobe takes effect in the cycle it is presented. A timeout setting of `PRE_TICKS` ticks or less must not be combined with the early warning. Such a load starts below the warning point, so the warning never fires.

Top module: `coarse_watchdog`

## Requirements
- R1: After reset, the count, control byte and status byte all read 0, and both `nmi_o` and `rst_req_o` are low.
- R2: A write to byte address 0x70 loads the count with `bus_wdata`. A read of 0x70 returns the live remaining count. This holds for any value up to 0xFFFF.
- R3: While control bit 0 (run) is 1, the count falls by exactly one every `TICK_CYCLES` clocks. The first decrement comes `TICK_CYCLES` clocks after the edge that took the count write, because the prescaler restarts on each load.
- R4: Address 0x72 holds the control byte, and all 8 bits read back as written. While run is 0, the count does not change.
- R5: The count stops at 0 and never wraps. A step from 1 to 0 sets status bit 1 (timeout).
- R6: When the count steps to 0 with control bit 7 (reset enable) set, `rst_req_o` is high for exactly one cycle and run clears to 0. With bit 7 clear, there is no reset request and run stays 1.
- R7: When the count steps from `PRE_TICKS`+1 to `PRE_TICKS` with control bit 2 (early-warning enable) set, status bit 2 is set, and `nmi_o` equals status bit 2. A load at or below `PRE_TICKS` never sets it, and neither does a run with bit 2 clear.
- R8: Writing 1 to a status bit at address 0x6E clears it, and bits written as 0 keep their value. A count reload leaves pending status bits set.
- R9: A read of 0x6E returns the status byte in bits 7:0. Other addresses read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_wdata | input | CNT_W | Write data (the control and status registers use bits 7:0) |
| bus_rdata | output | CNT_W | Read data for `bus_addr`, combinational |
| nmi_o | output | 1 | Early-warning interrupt, level, follows status bit 2 |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
The main pattern is a sweep of every reload value from 1 to 80 with run, reset and warning all enabled. The count, `nmi_o` and `rst_req_o` are compared in every cycle against a formula in the cycle index. This separates loads below, at and just above the warning point, and it checks the exact tick spacing and expiry cycle. The same sweep points are then repeated with reset disabled, with the warning disabled, and with a reload of 0. These runs tell the control bits apart from one another. Separate sequences check the keepalive reload, stopping mid-count, write-one-to-clear and unmapped addresses, because each of these can fail without disturbing the countdown itself.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Byte addresses within the register window
  localparam int unsigned OFS_STATUS = 'h6E;
  localparam int unsigned OFS_COUNT  = 'h70;
  localparam int unsigned OFS_CTRL   = 'h72;

  // Control byte bit positions
  localparam int unsigned CB_RUN    = 0;
  localparam int unsigned CB_PREEN  = 2;
  localparam int unsigned CB_RSTEN  = 7;

  // Status byte bit positions
  localparam int unsigned SB_EXPIRE = 1;
  localparam int unsigned SB_EARLY  = 2;

  typedef struct packed {
    logic early;
    logic expire;
  } wdt_status_t;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int unsigned TICK_CYCLES = 128000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  generate
    if (TICK_CYCLES <= 1) begin : g_direct
      assign tick_o = run_i && !restart_i;
    end else begin : g_div
      localparam int unsigned PW = $clog2(TICK_CYCLES);
      localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);
      logic [PW-1:0] phase_q;

      assign tick_o = run_i && !restart_i && (phase_q == LAST);

      always_ff @(posedge clk) begin
        if (!rst_n || restart_i || !run_i) begin
          phase_q <= '0;
        end else if (phase_q == LAST) begin
          phase_q <= '0;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PRE_TICKS = 70
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             hit_early_o,
  output logic             hit_zero_o
);
  localparam logic [CNT_W-1:0] EARLY_FROM = CNT_W'(PRE_TICKS + 1);
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step        = tick_i && !load_i && (cnt_q != '0);
  assign hit_early_o = step && (cnt_q == EARLY_FROM);
  assign hit_zero_o  = step && (cnt_q == ONE);
  assign count_o     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (step) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_csr.sv
module wdt_csr
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              hit_early_i,
  input  logic              hit_zero_i,
  output logic              load_o,
  output logic [7:0]        ctrl_o,
  output logic              nmi_o,
  output logic              rst_req_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

  logic [7:0]  ctrl_q;
  wdt_status_t stat_q, stat_d;
  logic        wr_ctrl, wr_stat, fire;
  logic [7:0]  stat_byte;
  logic        rst_q;

  assign load_o  = bus_wr && (bus_addr == A_CNT);
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign fire    = hit_zero_i && ctrl_q[CB_RSTEN];

  always_comb begin
    stat_byte            = '0;
    stat_byte[SB_EXPIRE] = stat_q.expire;
    stat_byte[SB_EARLY]  = stat_q.early;
  end

  // status: hardware set wins over a same-cycle write-one-to-clear
  always_comb begin
    stat_d = stat_q;
    if (wr_stat) begin
      if (bus_wdata[SB_EXPIRE]) stat_d.expire = 1'b0;
      if (bus_wdata[SB_EARLY])  stat_d.early  = 1'b0;
    end
    if (hit_zero_i) stat_d.expire = 1'b1;
    if (hit_early_i && ctrl_q[CB_PREEN]) stat_d.early = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
      rst_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      rst_q  <= fire;
      if (wr_ctrl) begin
        ctrl_q <= bus_wdata[7:0];
      end else if (fire) begin
        ctrl_q[CB_RUN] <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_CNT:   bus_rdata = count_i;
      A_CTRL:  bus_rdata = CNT_W'(ctrl_q);
      A_STAT:  bus_rdata = CNT_W'(stat_byte);
      default: bus_rdata = '0;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign nmi_o     = stat_q.early;
  assign rst_req_o = rst_q;
endmodule

// File: rtl/coarse_watchdog.sv
module coarse_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 128000,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PRE_TICKS   = 70,
  parameter int unsigned ADDR_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              nmi_o,
  output logic              rst_req_o
);
  logic             load_w, tick_w, hit_early_w, hit_zero_w;
  logic [CNT_W-1:0] cnt_w;
  logic [7:0]       ctrl_w;

  wdt_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (ctrl_w[CB_RUN]),
    .restart_i (load_w),
    .tick_o    (tick_w)
  );

  wdt_downcount #(.CNT_W(CNT_W), .PRE_TICKS(PRE_TICKS)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_w),
    .load_val_i  (bus_wdata),
    .tick_i      (tick_w),
    .count_o     (cnt_w),
    .hit_early_o (hit_early_w),
    .hit_zero_o  (hit_zero_w)
  );

  wdt_csr #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_csr (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .count_i     (cnt_w),
    .hit_early_i (hit_early_w),
    .hit_zero_i  (hit_zero_w),
    .load_o      (load_w),
    .ctrl_o      (ctrl_w),
    .nmi_o       (nmi_o),
    .rst_req_o   (rst_req_o)
  );
endmodule

// File: rtl/coarse_watchdog_chk.sv
module coarse_watchdog_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count_q,
  input logic             load,
  input logic             run,
  input logic             pre_en,
  input logic             rst_req,
  input logic             nmi
);
  // R6: the reset request lasts a single cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R6: a reset request only appears with the count at zero and run cleared
  a_r6_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (count_q == '0) && !run);

  // R5: a zero count without a load stays zero
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count_q == '0) |=> (count_q == '0));

  // R3: without a load the count moves only by one step down
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count_q != '0) |=> (count_q == $past(count_q)) || (count_q == $past(count_q) - 1'b1));

  // R4: a stopped counter holds its value
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !run) |=> $stable(count_q));

  // R7: the interrupt rises only when early warning was enabled
  a_r7_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi) |-> $past(pre_en));
endmodule

bind coarse_watchdog coarse_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .count_q (cnt_w),
  .load    (load_w),
  .run     (ctrl_w[0]),
  .pre_en  (ctrl_w[2]),
  .rst_req (rst_req_o),
  .nmi     (nmi_o)
);

// File: tb/tb_coarse_watchdog.sv
`timescale 1ns/1ps
module tb_coarse_watchdog;
  localparam int T   = 4;
  localparam int PRE = 70;
  localparam int CW  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [6:0]    bus_addr = 7'h70;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic          nmi_o, rst_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  coarse_watchdog #(.TICK_CYCLES(T), .CNT_W(CW), .PRE_TICKS(PRE), .ADDR_W(7)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nmi_o(nmi_o), .rst_req_o(rst_req_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one write; returns at the negedge after the capturing edge
  task automatic wr(input logic [6:0] a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = CW'(d);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 7'h70;
  endtask

  task automatic rd(input logic [6:0] a, output int v);
    bus_addr = a;
    #0.5;
    v = int'(bus_rdata);
    bus_addr = 7'h70;
    #0.1;
  endtask

  // full countdown from reload r under control byte c, checked every cycle
  task automatic run_case(input int r, input int c);
    int v, left, last;
    bit en_rst, en_pre, run;
    en_rst = c[7]; en_pre = c[2]; run = c[0];
    wr(7'h72, 0);
    wr(7'h6E, 'hFF);
    wr(7'h70, 0);
    wr(7'h72, c);
    wr(7'h70, r);
    last = r * T + 2;
    for (int k = 0; k <= last; k++) begin
      left = run ? ((r - k / T) > 0 ? r - k / T : 0) : r;
      rd(7'h70, v);
      chk("R3 count", v, left);
      chk("R6 rst_req", int'(rst_req_o), int'(en_rst && run && r > 0 && k == r * T));
      chk("R7 nmi", int'(nmi_o), int'(en_pre && run && r > PRE && left <= PRE));
      @(negedge clk);
    end
    rd(7'h6E, v);
    chk("R5 status expire", (v >> 1) & 1, int'(run && r > 0));
    chk("R7 status early", (v >> 2) & 1, int'(en_pre && run && r > PRE));
    rd(7'h72, v);
    chk("R6 run bit after expiry", v, (en_rst && r > 0) ? (c & 'hFE) : c);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v, held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(7'h70, v); chk("R1 count", v, 0);
    rd(7'h72, v); chk("R1 ctrl", v, 0);
    rd(7'h6E, v); chk("R1 status", v, 0);
    chk("R1 nmi", int'(nmi_o), 0);
    chk("R1 rst_req", int'(rst_req_o), 0);

    // R2 full-range load and readback while stopped
    wr(7'h70, 'hFFFF); rd(7'h70, v); chk("R2 load max", v, 'hFFFF);
    wr(7'h70, 'h1234); rd(7'h70, v); chk("R2 load", v, 'h1234);
    // R4 all control bits read back
    wr(7'h72, 'h5A); rd(7'h72, v); chk("R4 ctrl readback", v, 'h5A);
    rd(7'h70, v); chk("R4 stopped holds", v, 'h1234);

    // main sweep: R3 R5 R6 R7
    for (int r = 1; r <= 80; r++) run_case(r, 'h85);
    run_case(75, 'h81);
    run_case(75, 'h05);
    run_case(3, 'h01);
    run_case(0, 'h85);
    run_case(72, 'h84);

    // R2 live count differs from written value; R8 keepalive keeps status
    wr(7'h72, 0); wr(7'h6E, 'hFF);
    wr(7'h72, 'h85);
    wr(7'h70, 100);
    repeat (40 * T) @(negedge clk);
    rd(7'h70, v); chk("R2 live count", v, 60);
    chk("R7 nmi after crossing", int'(nmi_o), 1);
    wr(7'h70, 100);
    rd(7'h70, v); chk("R2 keepalive reload", v, 100);
    chk("R8 reload keeps nmi", int'(nmi_o), 1);
    rd(7'h6E, v); chk("R8 reload keeps status", v, 'h04);
    // R4 stop mid-count
    wr(7'h72, 'h84);
    rd(7'h70, held);
    repeat (5 * T) @(negedge clk);
    rd(7'h70, v); chk("R4 frozen count", v, held);
    rd(7'h72, v); chk("R4 ctrl after stop", v, 'h84);
    chk("R6 no rst while stopped", int'(rst_req_o), 0);

    // R8 write-one-to-clear per bit
    wr(7'h72, 'h05); wr(7'h70, 1);
    repeat (2 * T) @(negedge clk);
    rd(7'h6E, v); chk("R8 both set", v, 'h06);
    wr(7'h6E, 'h02);
    rd(7'h6E, v); chk("R8 clear expire only", v, 'h04);
    chk("R8 nmi kept", int'(nmi_o), 1);
    wr(7'h6E, 'h04);
    rd(7'h6E, v); chk("R8 clear early", v, 0);
    chk("R8 nmi cleared", int'(nmi_o), 0);

    // R9 unmapped address
    wr(7'h72, 'h80); wr(7'h70, 'h0777);
    wr(7'h60, 'hFFFF);
    wr(7'h71, 'hFFFF);
    rd(7'h60, v); chk("R9 unmapped read", v, 0);
    rd(7'h70, v); chk("R9 count untouched", v, 'h0777);
    rd(7'h72, v); chk("R9 ctrl untouched", v, 'h80);
    rd(7'h6E, v); chk("R9 status untouched", v, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule